// File: doc/BRIEF.md
# Write-Back Cache Flush Sequencer

This block keeps a frame buffer in external memory coherent with a write-back cache: the cache holds 2 ways of 128 sets with 256-byte lines, and a display engine reads the memory behind it. The sequencer steps through the cache's line slots. It reads each slot's dirty flag over a lookup port and hands every dirty line to a write-back port. After each accepted write-back it clears that line's dirty flag and leaves the valid flag alone. The cache data path and the memory controller sit outside the block.

Three mode bits are held in a register elsewhere. `mode_color` enables all flushing, because coherence only matters while the colour display is shown. `mode_vsync` lets every vertical-sync pulse start a full flush. `mode_auto` turns on a background cleaner that services one slot per `AUTO_PERIOD` clocks (1024 by default). A software command starts a full flush at any time while colour mode is on. A full flush walks slot indices 0 to 255, where index = set*2 + way. So the sets go in ascending order and, within a set, way 0 comes before way 1.

The FSM states are `ST_IDLE`, `ST_FULL_LOOK`, `ST_FULL_WB`, `ST_AUTO_LOOK` and `ST_AUTO_WB`, and they move as follows:

- **Leaving `ST_IDLE`:**
  - An enabled trigger moves it to `ST_FULL_LOOK` and resets the walk index to 0.
  - Otherwise a pending auto tick moves it to `ST_AUTO_LOOK`.
- **`ST_FULL_LOOK`:**
  - A dirty slot moves it to `ST_FULL_WB`.
  - A clean slot that is not the last advances the index and stays in the state.
  - A clean last slot returns it to `ST_IDLE`.
- **`ST_FULL_WB`:**
  - On acknowledge it returns to `ST_FULL_LOOK` with the next index.
  - If the slot was the last one, acknowledge returns it to `ST_IDLE` instead.
- **`ST_AUTO_LOOK`:**
  - A dirty slot moves it to `ST_AUTO_WB`.
  - A clean slot returns it to `ST_IDLE` and advances the round-robin pointer.
- **`ST_AUTO_WB`:**
  - On acknowledge it returns to `ST_IDLE` and advances the round-robin pointer.

Top module: `wbflush_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, `wb_req` and `dirty_clr` are 0.
- R2: When `sw_flush` is 1 at a clock edge with `mode_color`=1 and the block idle, `busy` is 1 from the next cycle and a full flush runs.
- R3: With `mode_color`=0, `sw_flush`, `vsync_pulse` and the auto timer start nothing: `busy` and `wb_req` stay 0.
- R4: `vsync_pulse` starts a full flush only when `mode_vsync`=1. With `mode_vsync`=0 it is ignored.
- R5: A full flush visits slots in ascending index order (index = set*2 + way, set on `slot_set`, way on `slot_way`). A clean slot takes exactly one cycle, so a flush of a fully clean cache keeps `busy` high for 256 cycles.
- R6: For a dirty slot, `wb_req` is raised with `slot_set`/`slot_way` held stable until `wb_ack`. `dirty_clr` is 1 in the cycle `wb_ack` is 1, with the same address. A dirty slot costs one lookup cycle plus the cycles `wb_req` is high.
- R7: `busy` stays 1 until the last slot's lookup or write-back completes, and is 0 in the following cycle.
- R8: A trigger that arrives while a full flush is running is merged into it. No second flush follows, and `busy` stays 0 after the running flush ends.
- R9: With `mode_color`=1 and `mode_auto`=1, exactly one slot is serviced per `AUTO_PERIOD` clocks.
  - The slot comes from a round-robin pointer that starts at 0 after reset, advances by one per service and wraps from 255 to 0.
  - A full trigger takes priority and drops a pending auto service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_color | input | 1 | Colour display active; enables all flushing |
| mode_vsync | input | 1 | Full flush on each vsync pulse |
| mode_auto | input | 1 | Background one-slot-per-period cleaning |
| sw_flush | input | 1 | Software full-flush command (one-cycle pulse) |
| vsync_pulse | input | 1 | Vertical sync pulse |
| slot_set | output | SET_W (7) | Set of the slot being looked up / written back / cleared |
| slot_way | output | WAY_W (1) | Way of that slot |
| line_dirty | input | 1 | Dirty flag of the addressed slot, returned in the same cycle |
| dirty_clr | output | 1 | Clear the dirty flag of the addressed slot |
| wb_req | output | 1 | Write-back request for the addressed line |
| wb_ack | input | 1 | Write-back accepted |
| busy | output | 1 | Full flush in progress |

## Verification
Every output is decoded from the registered state, so a trigger seen at one edge shows as `busy` one cycle later. Every acknowledge shows as `dirty_clr` in the same cycle. The bench drives inputs and samples outputs on falling edges, and checks `dirty_clr` 1 ns after it raises `wb_ack`. The length of a full flush is predicted exactly as 256 plus, for each dirty slot, one cycle plus the acknowledge latency the bench itself chooses, and the measured busy span is compared against it. Auto ticks are checked in a window of `AUTO_PERIOD` cycles with an 8-cycle margin. In that window the service for tick k completes about 3 cycles after k periods and before the next tick. The bench sets `AUTO_PERIOD` to 32 so that the pointer wrap fits in the run.

// File: rtl/wbflush_pkg.sv
package wbflush_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FULL_LOOK,
        ST_FULL_WB,
        ST_AUTO_LOOK,
        ST_AUTO_WB
    } fls_state_e;

endpackage

// File: rtl/fls_period_timer.sv
module fls_period_timer #(
    parameter int PERIOD = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] CLAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CLAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3
    stopped_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tick);

    // R9
    tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));

endmodule

// File: rtl/fls_slot_counter.sv
module fls_slot_counter #(
    parameter int SLOTS = 256
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       adv,
    output logic [$clog2(SLOTS)-1:0]   idx,
    output logic                       at_last
);
    localparam int IW = $clog2(SLOTS);
    localparam logic [IW-1:0] ILAST = IW'(SLOTS - 1);

    logic [IW-1:0] idx_q;

    assign idx     = idx_q;
    assign at_last = (idx_q == ILAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx_q <= '0;
        end else if (adv) begin
            idx_q <= at_last ? '0 : idx_q + 1'b1;
        end
    end

    // R9
    slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && idx_q == ILAST) |=> (idx_q == '0));

    // R5
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(idx_q));

endmodule

// File: rtl/wbflush_seq.sv
module wbflush_seq
    import wbflush_pkg::*;
#(
    parameter int SETS        = 128,
    parameter int WAYS        = 2,
    parameter int AUTO_PERIOD = 1024,
    localparam int SET_W      = $clog2(SETS),
    localparam int WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_color,
    input  logic             mode_vsync,
    input  logic             mode_auto,
    input  logic             sw_flush,
    input  logic             vsync_pulse,
    output logic [SET_W-1:0] slot_set,
    output logic [WAY_W-1:0] slot_way,
    input  logic             line_dirty,
    output logic             dirty_clr,
    output logic             wb_req,
    input  logic             wb_ack,
    output logic             busy
);
    localparam int SLOTS  = SETS * WAYS;
    localparam int SLOT_W = $clog2(SLOTS);

    fls_state_e state_q, state_d;

    logic              full_trig;
    logic              auto_tick;
    logic              auto_pend_q;
    logic              start_full;
    logic              start_auto;
    logic              walk_clr, walk_adv, walk_last;
    logic              rr_adv, rr_last;
    logic [SLOT_W-1:0] walk_idx, rr_idx, cur_idx;

    // ---------------------------------------------------------------
    // Trigger qualification
    // ---------------------------------------------------------------
    assign full_trig  = mode_color && (sw_flush || (mode_vsync && vsync_pulse));
    assign start_full = (state_q == ST_IDLE) && full_trig;
    assign start_auto = (state_q == ST_IDLE) && !full_trig && auto_pend_q;

    fls_period_timer #(.PERIOD(AUTO_PERIOD)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (mode_color && mode_auto),
        .tick  (auto_tick)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_pend_q <= 1'b0;
        end else if (auto_tick) begin
            auto_pend_q <= 1'b1;
        end else if (start_full || start_auto) begin
            auto_pend_q <= 1'b0;
        end
    end

    // ---------------------------------------------------------------
    // Slot pointers: full-flush walker and auto round-robin
    // ---------------------------------------------------------------
    assign walk_clr = start_full;
    assign walk_adv = ((state_q == ST_FULL_LOOK) && !line_dirty) ||
                      ((state_q == ST_FULL_WB) && wb_ack);
    assign rr_adv   = ((state_q == ST_AUTO_LOOK) && !line_dirty) ||
                      ((state_q == ST_AUTO_WB) && wb_ack);

    fls_slot_counter #(.SLOTS(SLOTS)) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (walk_clr),
        .adv     (walk_adv),
        .idx     (walk_idx),
        .at_last (walk_last)
    );

    fls_slot_counter #(.SLOTS(SLOTS)) u_rr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (1'b0),
        .adv     (rr_adv),
        .idx     (rr_idx),
        .at_last (rr_last)
    );

    // ---------------------------------------------------------------
    // State register
    // ---------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------------------------------------------------------
    // Next state
    // ---------------------------------------------------------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_full) begin
                    state_d = ST_FULL_LOOK;
                end else if (start_auto) begin
                    state_d = ST_AUTO_LOOK;
                end
            end
            ST_FULL_LOOK: begin
                if (line_dirty) begin
                    state_d = ST_FULL_WB;
                end else if (walk_last) begin
                    state_d = ST_IDLE;
                end
            end
            ST_FULL_WB: begin
                if (wb_ack) begin
                    state_d = walk_last ? ST_IDLE : ST_FULL_LOOK;
                end
            end
            ST_AUTO_LOOK: begin
                state_d = line_dirty ? ST_AUTO_WB : ST_IDLE;
            end
            ST_AUTO_WB: begin
                if (wb_ack) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------------------------------------------------------
    // Outputs
    // ---------------------------------------------------------------
    always_comb begin
        busy      = 1'b0;
        wb_req    = 1'b0;
        dirty_clr = 1'b0;
        cur_idx   = walk_idx;
        unique case (state_q)
            ST_IDLE: begin
                cur_idx = walk_idx;
            end
            ST_FULL_LOOK: begin
                busy = 1'b1;
            end
            ST_FULL_WB: begin
                busy      = 1'b1;
                wb_req    = 1'b1;
                dirty_clr = wb_ack;
            end
            ST_AUTO_LOOK: begin
                cur_idx = rr_idx;
            end
            ST_AUTO_WB: begin
                cur_idx   = rr_idx;
                wb_req    = 1'b1;
                dirty_clr = wb_ack;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    generate
        if (WAYS > 1) begin : g_multi_way
            assign slot_way = cur_idx[WAY_W-1:0];
            assign slot_set = cur_idx[SLOT_W-1:WAY_W];
        end else begin : g_single_way
            assign slot_way = 1'b0;
            assign slot_set = cur_idx[SET_W-1:0];
        end
    endgenerate

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !wb_req && !dirty_clr));

    // R2
    sw_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && mode_color && sw_flush) |=> busy);

    // R3
    color_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !mode_color && !auto_pend_q) |=> (!busy && !wb_req));

    // R6
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(slot_set) && $stable(slot_way)));

    // R6
    clr_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_clr |-> (wb_req && wb_ack));

    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wb_req && !line_dirty && walk_last) |=> !busy);

    // R8
    merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && walk_idx != '0) |=> (walk_idx != '0 || !busy));

endmodule

// File: tb/wbflush_seq_tb.sv
module wbflush_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SETS  = 128;
    localparam int WAYS  = 2;
    localparam int SLOTS = SETS * WAYS;
    localparam int APER  = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_color = 1'b0, mode_vsync = 1'b0, mode_auto = 1'b0;
    logic       sw_flush = 1'b0, vsync_pulse = 1'b0;
    logic [6:0] slot_set;
    logic [0:0] slot_way;
    logic       line_dirty;
    logic       dirty_clr, wb_req, busy;
    logic       wb_ack = 1'b0;

    logic [SLOTS-1:0] dmem = '0;
    bit               sticky = 1'b0;
    int               salt = 0;
    int               wcnt = 0;
    int               wb_log [0:1023];
    int               log_n = 0;
    int               n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign line_dirty = dmem[{slot_set, slot_way}];

    wbflush_seq #(.SETS(SETS), .WAYS(WAYS), .AUTO_PERIOD(APER)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .mode_color(mode_color), .mode_vsync(mode_vsync), .mode_auto(mode_auto),
        .sw_flush(sw_flush), .vsync_pulse(vsync_pulse),
        .slot_set(slot_set), .slot_way(slot_way), .line_dirty(line_dirty),
        .dirty_clr(dirty_clr), .wb_req(wb_req), .wb_ack(wb_ack), .busy(busy)
    );

    function automatic int dly(input int a);
        return (a * 5 + salt) % 4;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Write-back responder: acknowledge after dly() cycles, check dirty_clr (R6)
    always @(negedge clk) begin
        if (wb_ack) begin
            wb_ack = 1'b0;
            wcnt   = 0;
        end else if (wb_req && rst_n) begin
            int a;
            a = int'({slot_set, slot_way});
            if (wcnt >= dly(a)) begin
                wb_ack = 1'b1;
                if (log_n < 1024) wb_log[log_n] = a;
                log_n++;
                #1;
                chk(dirty_clr == 1'b1, "R6 dirty_clr with ack", int'(dirty_clr), 1);
                if (!sticky) dmem[a] = 1'b0;
            end else begin
                wcnt++;
            end
        end
    end

    task automatic run_full(input bit use_vsync, input int merge_at, input string tag);
        int exp_list [0:SLOTS-1];
        int exp_n = 0;
        int exp_cyc = SLOTS;
        int cyc = 0;
        for (int i = 0; i < SLOTS; i++) begin
            if (dmem[i]) begin
                exp_list[exp_n] = i;
                exp_n++;
                exp_cyc += 1 + dly(i);
            end
        end
        log_n = 0;
        if (use_vsync) vsync_pulse = 1'b1; else sw_flush = 1'b1;
        @(negedge clk);
        vsync_pulse = 1'b0;
        sw_flush    = 1'b0;
        chk(busy == 1'b1, "R2 busy after trigger", int'(busy), 1);
        cyc = 1;
        while (busy && cyc < 5000) begin
            sw_flush = (cyc == merge_at);
            @(negedge clk);
            if (busy) cyc++;
        end
        sw_flush = 1'b0;
        chk(cyc == exp_cyc, {"R5/R7 busy span ", tag}, cyc, exp_cyc);
        chk(log_n == exp_n, {"R6 write-back count ", tag}, log_n, exp_n);
        for (int k = 0; k < exp_n && k < log_n; k++) begin
            chk(wb_log[k] == exp_list[k], {"R5 write-back order ", tag}, wb_log[k], exp_list[k]);
        end
        chk(dmem == '0, {"R6 all clean after flush ", tag}, $countones(dmem), 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(busy == 1'b0, {"R8 no second flush ", tag}, int'(busy), 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
        chk(wb_req == 1'b0, "R1 wb_req in reset", int'(wb_req), 0);
        chk(dirty_clr == 1'b0, "R1 dirty_clr in reset", int'(dirty_clr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);

        // R3 colour off: everything ignored
        dmem = '1;
        mode_vsync = 1'b1; mode_auto = 1'b1;
        sw_flush = 1'b1; vsync_pulse = 1'b1;
        @(negedge clk);
        sw_flush = 1'b0; vsync_pulse = 1'b0;
        for (int k = 0; k < APER + 8; k++) begin
            chk(busy == 1'b0 && wb_req == 1'b0, "R3 colour off ignored", int'(busy | wb_req), 0);
            @(negedge clk);
        end
        chk(log_n == 0, "R3 no write-back", log_n, 0);
        mode_auto = 1'b0; mode_vsync = 1'b0;
        dmem = '0;

        // R5 fully clean flush: 256 busy cycles
        mode_color = 1'b1;
        @(negedge clk);
        run_full(1'b0, -1, "clean");

        // R4 vsync gated by mode_vsync
        vsync_pulse = 1'b1;
        @(negedge clk);
        vsync_pulse = 1'b0;
        chk(busy == 1'b0, "R4 vsync ignored when disabled", int'(busy), 0);
        @(negedge clk);
        mode_vsync = 1'b1;
        dmem[7] = 1'b1; dmem[200] = 1'b1;
        run_full(1'b1, -1, "vsync");

        // Directed corners: last slot only (R7), first only, all dirty
        dmem = '0; dmem[SLOTS-1] = 1'b1; salt = 3;
        run_full(1'b0, -1, "last slot R7");
        dmem = '0; dmem[0] = 1'b1; salt = 1;
        run_full(1'b0, 5, "first slot");
        dmem = '1; salt = 0;
        run_full(1'b0, 300, "all dirty");

        // Random patterns with merged triggers (R8)
        for (int it = 0; it < 8; it++) begin
            int dens;
            dens = $urandom_range(1, 9);
            for (int i = 0; i < SLOTS; i++) dmem[i] = ($urandom_range(0, 9) < dens);
            salt = $urandom_range(0, 3);
            run_full(1'(it % 2), $urandom_range(2, 250), "random R8");
        end

        // R9 auto mode: all slots sticky dirty, one service per period, wrap
        mode_vsync = 1'b0;
        sticky = 1'b1; dmem = '1; salt = 0; log_n = 0;
        mode_auto = 1'b1;
        repeat (APER * 260 + 8) @(negedge clk);
        chk(log_n == 260, "R9 one service per period", log_n, 260);
        for (int k = 0; k < 260 && k < log_n; k++) begin
            chk(wb_log[k] == (k % SLOTS), "R9 round-robin order and wrap", wb_log[k], k % SLOTS);
        end
        chk(busy == 1'b0, "R9 auto leaves busy low", int'(busy), 0);
        mode_auto = 1'b0;
        sticky = 1'b0;
        repeat (10) @(negedge clk);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule